// File: doc/BRIEF.md
# Strobed Input Handshake Port

This block is a latched input port that a peripheral fills under a strobe handshake. The strobe is active low. When it returns high, the value on the peripheral data bus is stored in an input latch and a buffer-full flag is raised. If the host has enabled interrupts, an interrupt request then tells the host CPU that a byte is waiting. The host empties the port by reading the data register. The interrupt request drops as soon as that read starts, and the buffer-full flag clears when the read ends.

The host sees four byte addresses on a simple synchronous register bus with chip select, read and write.
- Address 0 is the data register.
- Address 1 is reserved.
- Address 2 is the control/status byte. It reports the handshake flags and holds two general-purpose output bits.
- Address 3 takes single-bit set/reset commands. These program the interrupt-enable bit and the general-purpose bits.

The strobe comes from the peripheral without any timing relation to the clock, so it passes through a synchronizer before its rising edge is detected.

Top module: `strobed_input_port`

## Requirements
- R1: Reset (rst_ni low) clears the input latch, buffer-full, interrupt request, interrupt enable and the general-purpose bits. Every register then reads 0.
- R2: A 0-to-1 transition on stb_ni loads pdata_i into the latch and sets full_o. A later read of address 0 returns the captured value.
- R3: full_o stays set while a data-register read (cs_i=1, rd_i=1, addr_i=0) is held. It clears in the cycle after the read is released.
- R4: irq_o is high only when buffer-full is set, interrupt enable is 1 and the synchronized strobe is high. While stb_ni is held low, irq_o is 0 even if the buffer is full.
- R5: irq_o drops one cycle after a data-register read begins, while full_o is still set.
- R6: With interrupt enable at 0, a capture sets full_o but irq_o stays 0. Clearing interrupt enable while irq_o is high drops irq_o.
- R7: A write to address 3 with wdata_i[7]=0 is a bit set/reset command. wdata_i[3:1] selects the bit and wdata_i[0] is the new value. Bit 4 is interrupt enable, and bits 7 and 6 drive gp_o[1] and gp_o[0]. Selecting any other bit changes nothing. A write to address 3 with wdata_i[7]=1 is ignored.
- R8: Reading address 2 returns a status byte:
  - bit 7 = gp_o[1] and bit 6 = gp_o[0];
  - bit 5 = buffer-full;
  - bit 4 = interrupt enable;
  - bit 3 = interrupt request;
  - all other bits 0.

  Reading address 1 returns 0.
- R9: A new strobe while buffer-full is set overwrites the latch, and full_o stays set.
- R10: A direct write to address 2 updates only the general-purpose bits, from wdata_i[7:6]. A write with cs_i low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Host chip select |
| rd_i | input | 1 | Host read, level held for the access |
| wr_i | input | 1 | Host write, sampled each clock |
| addr_i | input | 2 | Host register address |
| wdata_i | input | DATA_W | Host write data |
| rdata_o | output | DATA_W | Host read data, zero when not reading |
| pdata_i | input | DATA_W | Peripheral data |
| stb_ni | input | 1 | Peripheral strobe, active low |
| full_o | output | 1 | Buffer full |
| irq_o | output | 1 | Interrupt request |
| gp_o | output | 2 | General-purpose latched bits |

## Verification
The bench builds the block with its defaults: an 8-bit data path and a two-stage strobe synchronizer. With these values the whole status byte can be compared bit for bit. The waits in the bench are longer than the three-cycle latency from strobe release to capture, so the checks do not depend on the exact synchronizer depth. With these defaults the bench can reach the following cases:
- a capture while the buffer is full;
- a strobe held low over a pending interrupt;
- a read that straddles several cycles;
- command writes that select bits with no writable target.

// File: rtl/sip_pkg.sv
package sip_pkg;
  localparam int CTRL_W   = 8;
  localparam int GP_W     = 2;
  localparam int BIT_IRQ  = 3;
  localparam int BIT_INTE = 4;
  localparam int BIT_FULL = 5;
  localparam int BIT_GP   = 6;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_RSVD = 2'd1,
    REG_CTRL = 2'd2,
    REG_CMD  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/sip_strobe_sync.sv
module sip_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_ni,
  output logic stb_high_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= stb_ni;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[STAGES-2:0], stb_ni};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[STAGES-1];

  assign stb_high_o = sync_q[STAGES-1];
  assign rise_o     = sync_q[STAGES-1] & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R2
endmodule

// File: rtl/sip_in_latch.sv
module sip_in_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              stb_high_i,
  input  logic [DATA_W-1:0] pdata_i,
  input  logic              inte_i,
  input  logic              rd_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] data_q;
  logic full_q, irq_q, rd_prev_q;
  logic rd_done, full_d, irq_d;

  assign rd_done = rd_prev_q & ~rd_data_i;
  // capture wins over a read completing in the same cycle
  assign full_d  = cap_i ? 1'b1 : (rd_done ? 1'b0 : full_q);
  assign irq_d   = inte_i & full_q & stb_high_i & ~rd_data_i & ~rd_done;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      data_q    <= '0;
      full_q    <= 1'b0;
      irq_q     <= 1'b0;
      rd_prev_q <= 1'b0;
    end else begin
      if (cap_i) data_q <= pdata_i;
      full_q    <= full_d;
      irq_q     <= irq_d;
      rd_prev_q <= rd_data_i;
    end

  assign data_o = data_q;
  assign full_o = full_q;
  assign irq_o  = irq_q;

  AST_FULL_ON_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> full_q); // R2
  AST_FULL_HELD_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && rd_data_i) |=> full_q); // R3
  AST_IRQ_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> full_q); // R4
  AST_IRQ_LOW_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_high_i |=> !irq_q); // R4
  AST_IRQ_DROP_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_i |=> !irq_q); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inte_i |=> !irq_q); // R6
endmodule

// File: rtl/sip_host_if.sv
module sip_host_if
  import sip_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              full_i,
  input  logic              irq_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              inte_o,
  output logic [GP_W-1:0]   gp_o,
  output logic              rd_data_o
);
  reg_sel_e sel;
  logic wr_en, rd_en, cmd_en, ctrl_en;
  logic [2:0] bit_sel;
  logic inte_q;
  logic [GP_W-1:0] gp_q;
  logic [CTRL_W-1:0] status;
  logic unused_wdata;

  assign sel     = reg_sel_e'(addr_i);
  assign wr_en   = cs_i & wr_i;
  assign rd_en   = cs_i & rd_i;
  assign cmd_en  = wr_en && (sel == REG_CMD) && !wdata_i[7];
  assign ctrl_en = wr_en && (sel == REG_CTRL);
  assign bit_sel = wdata_i[3:1];
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                                  inte_q <= 1'b0;
    else if (cmd_en && bit_sel == 3'(BIT_INTE))   inte_q <= wdata_i[0];

  for (genvar g = 0; g < GP_W; g++) begin : g_gp
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                                   gp_q[g] <= 1'b0;
      else if (ctrl_en)                              gp_q[g] <= wdata_i[BIT_GP+g];
      else if (cmd_en && bit_sel == 3'(BIT_GP + g))  gp_q[g] <= wdata_i[0];
  end

  always_comb begin
    status = '0;
    status[BIT_GP +: GP_W] = gp_q;
    status[BIT_FULL]       = full_i;
    status[BIT_INTE]       = inte_q;
    status[BIT_IRQ]        = irq_i;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      case (sel)
        REG_DATA: rdata_o = data_i;
        REG_CTRL: rdata_o = DATA_W'(status);
        default:  rdata_o = '0;
      endcase
    end
  end

  assign rd_data_o = rd_en && (sel == REG_DATA);
  assign inte_o    = inte_q;
  assign gp_o      = gp_q;

  AST_GP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(gp_q)); // R7
  AST_INTE_NO_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> $stable(inte_q)); // R10
  AST_INTE_CTRL_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && sel == REG_CTRL) |=> $stable(inte_q)); // R10
endmodule

// File: rtl/strobed_input_port.sv
module strobed_input_port
  import sip_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] pdata_i,
  input  logic              stb_ni,
  output logic              full_o,
  output logic              irq_o,
  output logic [GP_W-1:0]   gp_o
);
  logic stb_high, cap, inte, rd_data;
  logic [DATA_W-1:0] data;

  sip_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .stb_ni(stb_ni),
    .stb_high_o(stb_high), .rise_o(cap)
  );

  sip_in_latch #(.DATA_W(DATA_W)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap), .stb_high_i(stb_high),
    .pdata_i(pdata_i), .inte_i(inte), .rd_data_i(rd_data),
    .data_o(data), .full_o(full_o), .irq_o(irq_o)
  );

  sip_host_if #(.DATA_W(DATA_W)) u_host (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .rd_i(rd_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .data_i(data), .full_i(full_o),
    .irq_i(irq_o), .rdata_o(rdata_o), .inte_o(inte), .gp_o(gp_o),
    .rd_data_o(rd_data)
  );
endmodule

// File: tb/sim_strobed_input_port.sv
module sim_strobed_input_port;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs = 0, rd = 0, wr = 0, stb_n = 1;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, pdata = 0, rdata;
  logic full, irq;
  logic [1:0] gp;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  strobed_input_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pdata_i(pdata),
    .stb_ni(stb_n), .full_o(full), .irq_o(irq), .gp_o(gp)
  );

  // {inte, pdata}
  localparam logic [8:0] VEC [6] = '{
    {1'b1, 8'hA5}, {1'b0, 8'h3C}, {1'b1, 8'h00},
    {1'b1, 8'hFF}, {1'b0, 8'h81}, {1'b1, 8'h5A}
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(logic [7:0] d);
    @(negedge clk); pdata = d; stb_n = 0;
    repeat (3) @(negedge clk);
    stb_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic write(logic [1:0] a, logic [7:0] d, logic sel = 1);
    @(negedge clk); cs = sel; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic rd_begin(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    #1 d = rdata;
  endtask

  task automatic rd_end();
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
    rd_begin(a, d); rd_end();
  endtask

  function automatic logic [7:0] stat(logic [1:0] g, logic f, logic ie, logic iq);
    return {g, f, ie, iq, 3'b000};
  endfunction

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 full", {7'd0, full}, 0);
    chk("R1 irq", {7'd0, irq}, 0);
    rst_ni = 1;
    rd_reg(2, v); chk("R1 status", v, 0);
    rd_reg(0, v); chk("R1 data", v, 0);
    rd_reg(1, v); chk("R8 reserved", v, 0);

    foreach (VEC[i]) begin
      logic ie = VEC[i][8];
      logic [7:0] d = VEC[i][7:0];
      write(3, {4'b0, 3'd4, ie});
      strobe(d);
      chk("R2 full set", {7'd0, full}, 1);
      chk(ie ? "R4 irq" : "R6 irq masked", {7'd0, irq}, {7'd0, ie});
      rd_reg(2, v); chk("R8 status", v, stat(2'b00, 1, ie, ie));
      rd_begin(0, v); chk("R2 data", v, d);
      @(negedge clk);
      chk("R5 irq drop", {7'd0, irq}, 0);
      chk("R3 full held", {7'd0, full}, 1);
      cs = 0; rd = 0;
      repeat (2) @(negedge clk);
      chk("R3 full clear", {7'd0, full}, 0);
    end

    // R9 overwrite
    write(3, 8'h09);
    strobe(8'h11); strobe(8'h22);
    chk("R9 full", {7'd0, full}, 1);
    // R4 strobe low suppresses irq
    chk("R4 irq pre", {7'd0, irq}, 1);
    @(negedge clk); pdata = 8'h22; stb_n = 0;
    repeat (5) @(negedge clk);
    chk("R4 irq stb low", {7'd0, irq}, 0);
    chk("R4 full stb low", {7'd0, full}, 1);
    stb_n = 1; repeat (6) @(negedge clk);
    chk("R4 irq stb high", {7'd0, irq}, 1);
    // R7 other selections have no effect
    write(3, 8'h0A); write(3, 8'h06);
    chk("R7 full kept", {7'd0, full}, 1);
    chk("R7 irq kept", {7'd0, irq}, 1);
    // R6 clearing enable drops irq
    write(3, 8'h08);
    @(negedge clk);
    chk("R6 irq cleared", {7'd0, irq}, 0);
    rd_reg(0, v); chk("R9 data", v, 8'h22);
    repeat (2) @(negedge clk);
    // R7 gp bits
    write(3, 8'h0D); write(3, 8'h0F);
    chk("R7 gp set", {6'd0, gp}, 2'b11);
    write(3, 8'h0C);
    chk("R7 gp6 clr", {6'd0, gp}, 2'b10);
    write(3, 8'h89);
    rd_reg(2, v); chk("R7 mode word ignored", v, stat(2'b10, 0, 0, 0));
    // R10 direct ctrl write and cs gating
    write(2, 8'h40);
    rd_reg(2, v); chk("R10 ctrl write", v, stat(2'b01, 0, 0, 0));
    write(3, 8'h09, 0); write(2, 8'hC0, 0);
    rd_reg(2, v); chk("R10 cs low", v, stat(2'b01, 0, 0, 0));
    // R1 reset mid-run
    write(3, 8'h09); strobe(8'h77);
    @(negedge clk); rst_ni = 0; #1;
    chk("R1 full rst", {7'd0, full}, 0);
    chk("R1 irq rst", {7'd0, irq}, 0);
    chk("R1 gp rst", {6'd0, gp}, 0);
    @(negedge clk); rst_ni = 1;
    rd_reg(0, v); chk("R1 data rst", v, 0);
    rd_reg(2, v); chk("R1 status rst", v, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule